// File: doc/BRIEF.md
# Cascadable Dual Event Counter

The block counts rising edges on two event inputs that run with no fixed relation to the system clock. Each input is brought into the clock domain by a synchronizer chain and an edge detector. Every detected rising edge is one count. There are two counters of `CntW` bits, called low and high.

In split mode each counter follows its own input. Each has its own enable bit and its own run bit, and the run bit acts as an active-low clear. In cascade mode the two counters form one counter of 2·`CntW` bits that counts the low input only. The high counter then advances on the carry out of the low counter.

Wrap events set sticky flags, and an interrupt output mirrors the flags one clock later. Software stops counting by clearing the enables before it reads back, so that the value it reads is exact. The mode bit can only be changed while both counters are stopped.

Top module: `evtcnt_top`

## Requirements
- R1: After reset (`rstN` low) every readback address returns 0 and `irq` is 0. The readback addresses are: 0 = control, 1 = flags, 2 = low count, 3 = high count.
- R2: In split mode (control bit 4 = 0), each counter goes up by exactly 1 for every rising edge of its own input while its enable bit and its run bit are both 1. The enable bits are control bit 0 (low) and bit 1 (high). The run bits are control bit 2 (low) and bit 3 (high). A counter wraps from all-ones to 0.
- R3: While a counter's run bit is 1 and its enable bit is 0, its value does not change. While its run bit is 0, the counter is held at 0.
- R4: In cascade mode (control bit 4 = 1), the low counter counts edges of the low input while its enable and run bits are 1. The high counter goes up by 1 on each wrap of the low counter while the high run bit is 1. Readback of addresses 3 and 2 together gives {high, low}.
- R5: In cascade mode, the high input and the high enable bit have no effect. Setting or clearing the high enable never adds a count to the high counter.
- R6: In split mode, a wrap of the low counter sets flag bit 0, and a wrap of the high counter sets flag bit 1.
- R7: In cascade mode, only a wrap of the full cascaded value from all-ones to 0 sets a flag, and that flag is bit 1. A wrap of the low counter alone sets no flag.
- R8: Flags stay set until software writes 1 to their bit position at address 1. Writing 0 to a bit leaves that flag unchanged. When a flag is set and cleared in the same cycle, the set wins.
- R9: `irq` is 1 in the cycle after any flag is 1, and 0 in the cycle after no flag is 1.
- R10: A write to address 0 always updates the enable and run bits. It updates the mode bit only if both enable bits were 0 before the write; otherwise the mode bit keeps its value.
- R11: No edge is lost for any duty cycle, provided the high and low times of the input are each at least two clock periods. A count appears in readback three clock edges after the first clock edge that samples the new input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtLo | input | 1 | Event input for the low counter, asynchronous |
| evtHi | input | 1 | Event input for the high counter, asynchronous |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | CntW | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | CntW | Readback data for rdAddr, combinational |
| irq | output | 1 | Wrap interrupt, registered |

## Verification
The bound checker checks several properties on every cycle:
- a stopped counter holds its value, and a counter whose run bit is 0 reads zero;
- a count only ever steps by one or wraps;
- in cascade mode, the high count holds whenever the low enable is clear;
- the mode bit changes only after both enables were clear;
- the interrupt follows the flags by one cycle.

The exact count against the number of edges driven can only be shown by the bench scenarios. So can the following:
- the ripple of the low wrap into the high half across thousands of edges;
- flags that stay quiet on low-half wraps in cascade mode;
- an ignored mode write;
- the minimum-width edge train.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;

  // Register addresses
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_LO   = 2'd2;
  localparam logic [1:0] ADDR_HI   = 2'd3;

  // Control field positions
  localparam int BIT_EN_LO  = 0;
  localparam int BIT_EN_HI  = 1;
  localparam int BIT_RUN_LO = 2;
  localparam int BIT_RUN_HI = 3;
  localparam int BIT_MODE   = 4;
  localparam int CTRL_W     = 5;

  // Strobes from control to datapath
  typedef struct packed {
    logic       incLo;    // count one on the low half
    logic       incHi;    // count one on the high half (split mode)
    logic       runLo;    // 0 forces low half to zero
    logic       runHi;    // 0 forces high half to zero
    logic       cascade;  // high half takes carries from the low half
    logic [1:0] flagClr;  // write-one-to-clear mask
  } evt_strobe_t;

endpackage

// File: rtl/evtcnt_sync.sv
module evtcnt_sync #(
  parameter int Stages = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic evtIn,
  output logic risePulse
);
  localparam int PipeW = Stages + 1;

  logic [PipeW-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[PipeW-2:0], evtIn};
  end

  // last sync stage high, edge-detect stage still low
  assign risePulse = pipe[Stages-1] & ~pipe[Stages];
endmodule

// File: rtl/evtcnt_ctrl.sv
module evtcnt_ctrl
  import evtcnt_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtLo,
  input  logic              evtHi,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CTRL_W-1:0] wrField,
  output evt_strobe_t       strobe,
  output logic [CTRL_W-1:0] ctrlView
);
  localparam int NumCh = 2;

  logic [NumCh-1:0] evtIn;
  logic [NumCh-1:0] rise;
  logic enLo, enHi, runLo, runHi, mode16;
  logic ctrlWr;

  assign evtIn  = {evtHi, evtLo};
  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);

  for (genvar c = 0; c < NumCh; c++) begin : g_sync
    evtcnt_sync #(.Stages(SyncStages)) u_sync (
      .clk      (clk),
      .rstN     (rstN),
      .evtIn    (evtIn[c]),
      .risePulse(rise[c])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enLo   <= 1'b0;
      enHi   <= 1'b0;
      runLo  <= 1'b0;
      runHi  <= 1'b0;
      mode16 <= 1'b0;
    end else if (ctrlWr) begin
      enLo  <= wrField[BIT_EN_LO];
      enHi  <= wrField[BIT_EN_HI];
      runLo <= wrField[BIT_RUN_LO];
      runHi <= wrField[BIT_RUN_HI];
      // mode is locked while either half is counting
      if (!enLo && !enHi) mode16 <= wrField[BIT_MODE];
    end
  end

  always_comb begin
    strobe.incLo   = rise[0] & enLo;
    strobe.incHi   = rise[1] & enHi & ~mode16;
    strobe.runLo   = runLo;
    strobe.runHi   = runHi;
    strobe.cascade = mode16;
    strobe.flagClr = (wrEn && wrAddr == ADDR_FLAG) ? wrField[1:0] : 2'b00;
  end

  assign ctrlView = {mode16, runHi, runLo, enHi, enLo};
endmodule

// File: rtl/evtcnt_datapath.sv
module evtcnt_datapath
  import evtcnt_pkg::*;
#(
  parameter int CntW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  evt_strobe_t     strobe,
  output logic [CntW-1:0] cntLo,
  output logic [CntW-1:0] cntHi,
  output logic [1:0]      flags,
  output logic            irq
);
  localparam logic [CntW-1:0] One = CntW'(1);

  logic loCarry, hiStep, setLo, setHi;

  always_comb begin
    loCarry = strobe.runLo & strobe.incLo & (&cntLo);
    hiStep  = strobe.cascade ? loCarry : strobe.incHi;
    setLo   = loCarry & ~strobe.cascade;
    setHi   = strobe.runHi & hiStep & (&cntHi);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLo <= '0;
      cntHi <= '0;
      flags <= 2'b00;
      irq   <= 1'b0;
    end else begin
      if (!strobe.runLo)     cntLo <= '0;
      else if (strobe.incLo) cntLo <= cntLo + One;
      if (!strobe.runHi)     cntHi <= '0;
      else if (hiStep)       cntHi <= cntHi + One;
      flags <= (flags & ~strobe.flagClr) | {setHi, setLo};
      irq   <= |flags;
    end
  end
endmodule

// File: rtl/evtcnt_top.sv
module evtcnt_top
  import evtcnt_pkg::*;
#(
  parameter int CntW       = 8,
  parameter int SyncStages = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            evtLo,
  input  logic            evtHi,
  input  logic            wrEn,
  input  logic [1:0]      wrAddr,
  input  logic [CntW-1:0] wrData,
  input  logic [1:0]      rdAddr,
  output logic [CntW-1:0] rdData,
  output logic            irq
);
  evt_strobe_t       strobe;
  logic [CTRL_W-1:0] ctrlView;
  logic [CntW-1:0]   cntLo, cntHi;
  logic [1:0]        flags;

  if (CntW > CTRL_W) begin : g_spare
    logic unusedWr;
    assign unusedWr = ^wrData[CntW-1:CTRL_W];
  end

  evtcnt_ctrl #(.SyncStages(SyncStages)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .evtLo   (evtLo),
    .evtHi   (evtHi),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrField (wrData[CTRL_W-1:0]),
    .strobe  (strobe),
    .ctrlView(ctrlView)
  );

  evtcnt_datapath #(.CntW(CntW)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .cntLo (cntLo),
    .cntHi (cntHi),
    .flags (flags),
    .irq   (irq)
  );

  always_comb begin
    unique case (rdAddr)
      ADDR_CTRL: rdData = CntW'(ctrlView);
      ADDR_FLAG: rdData = CntW'(flags);
      ADDR_LO:   rdData = cntLo;
      default:   rdData = cntHi;
    endcase
  end
endmodule

// File: rtl/evtcnt_checker.sv
module evtcnt_checker #(
  parameter int CntW = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            enLo,
  input logic            enHi,
  input logic            runLo,
  input logic            runHi,
  input logic            mode16,
  input logic [CntW-1:0] cntLo,
  input logic [CntW-1:0] cntHi,
  input logic [1:0]      flags,
  input logic            irq
);
  localparam logic [CntW-1:0] One = CntW'(1);

  // R3
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enLo && runLo) |=> (cntLo == $past(cntLo)));

  // R3
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!mode16 && !enHi && runHi) |=> (cntHi == $past(cntHi)));

  // R3
  lo_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runLo |=> (cntLo == '0));

  // R3
  hi_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runHi |=> (cntHi == '0));

  // R5
  hi_gate16_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode16 && !enLo && runHi) |=> (cntHi == $past(cntHi)));

  // R2
  lo_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntLo != $past(cntLo)) |-> (cntLo == $past(cntLo) + One || cntLo == '0));

  // R2
  hi_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntHi != $past(cntHi)) |-> (cntHi == $past(cntHi) + One || cntHi == '0));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|flags) |=> irq);

  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|flags) |=> !irq);

  // R10
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode16 != $past(mode16)) |-> (!$past(enLo) && !$past(enHi)));
endmodule

bind evtcnt_top evtcnt_checker #(.CntW(CntW)) chk (
  .clk   (clk),
  .rstN  (rstN),
  .enLo  (ctrlView[0]),
  .enHi  (ctrlView[1]),
  .runLo (ctrlView[2]),
  .runHi (ctrlView[3]),
  .mode16(ctrlView[4]),
  .cntLo (cntLo),
  .cntHi (cntHi),
  .flags (flags),
  .irq   (irq)
);

// File: tb/evtcnt_top_test.sv
`timescale 1ns/100ps
module evtcnt_top_test;
  localparam int W    = 6;
  localparam int MaxV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtLo = 1'b0, evtHi = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0, rdAddr = 2'd0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic irq;

  int total = 0, bad = 0;
  bit autoRd = 1'b1, checkOn = 1'b0;
  bit drvLo = 1'b0, drvHi = 1'b0;
  int minW = 2, maxW = 5;
  int edgesLo = 0, edgesHi = 0;

  always #2.5 clk = ~clk;

  evtcnt_top #(.CntW(W)) uut (
    .clk(clk), .rstN(rstN), .evtLo(evtLo), .evtHi(evtHi),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  // ---------------- reference model ----------------
  bit hLo[$], hHi[$];
  int mEnLo, mEnHi, mRunLo, mRunHi, mMode, mLo, mHi, mFLo, mFHi, mIrq;

  function automatic int ctrlVal();
    return mEnLo | (mEnHi << 1) | (mRunLo << 2) | (mRunHi << 3) | (mMode << 4);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      hLo = '{0, 0, 0, 0}; hHi = '{0, 0, 0, 0};
      mEnLo = 0; mEnHi = 0; mRunLo = 0; mRunHi = 0; mMode = 0;
      mLo = 0; mHi = 0; mFLo = 0; mFHi = 0; mIrq = 0;
    end else begin
      bit pLo, pHi, wrapLo;
      int setLo, setHi, nLo, nHi;
      hLo.push_front(evtLo); void'(hLo.pop_back());
      hHi.push_front(evtHi); void'(hHi.pop_back());
      pLo = hLo[2] && !hLo[3];
      pHi = hHi[2] && !hHi[3];
      wrapLo = 0; setLo = 0; setHi = 0;
      nLo = mLo; nHi = mHi;
      if (mRunLo == 0) nLo = 0;
      else if (pLo && mEnLo != 0) begin
        if (mLo == MaxV) begin nLo = 0; wrapLo = 1; end else nLo = mLo + 1;
      end
      if (mMode == 0 && wrapLo) setLo = 1;
      if (mRunHi == 0) nHi = 0;
      else if ((mMode != 0) ? wrapLo : (pHi && mEnHi != 0)) begin
        if (mHi == MaxV) begin nHi = 0; setHi = 1; end else nHi = mHi + 1;
      end
      mIrq = (mFLo | mFHi);
      if (wrEn && wrAddr == 2'd1) begin
        if (wrData[0]) mFLo = 0;
        if (wrData[1]) mFHi = 0;
      end
      if (setLo) mFLo = 1;
      if (setHi) mFHi = 1;
      mLo = nLo; mHi = nHi;
      if (wrEn && wrAddr == 2'd0) begin
        if (mEnLo == 0 && mEnHi == 0) mMode = wrData[4];
        mEnLo = wrData[0]; mEnHi = wrData[1];
        mRunLo = wrData[2]; mRunHi = wrData[3];
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (autoRd) rdAddr <= rdAddr + 2'd1;

  initial forever begin
    @(negedge clk); #1;
    if (rstN && checkOn) begin
      int exp;
      string req;
      case (rdAddr)
        2'd0: begin exp = ctrlVal();          req = "R10"; end
        2'd1: begin exp = mFLo | (mFHi << 1); req = "R6";  end
        2'd2: begin exp = mLo;                req = "R2";  end
        default: begin exp = mHi;             req = "R4";  end
      endcase
      check(req, "per-cycle readback", int'(rdData), exp);
      check("R9", "per-cycle irq", int'(irq), mIrq);
    end
  end

  // ---------------- stimulus helpers ----------------
  initial begin
    int remLo = 0, remHi = 0;
    forever begin
      @(negedge clk);
      if (drvLo) begin
        if (remLo <= 0) begin
          evtLo = ~evtLo;
          if (evtLo) edgesLo++;
          remLo = $urandom_range(maxW, minW) - 1;
        end else remLo--;
      end
      if (drvHi) begin
        if (remHi <= 0) begin
          evtHi = ~evtHi;
          if (evtHi) edgesHi++;
          remHi = $urandom_range(maxW, minW) - 1;
        end else remHi--;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output int v);
    autoRd = 1'b0;
    @(negedge clk);
    rdAddr = a;
    #1 v = int'(rdData);
    autoRd = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stopDrive();
    drvLo = 1'b0; drvHi = 1'b0;
    idle(6);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  // ---------------- scenarios ----------------
  initial begin
    int v, lo, hi, savLo, savHi;
    idle(3);
    rstN = 1'b1;
    checkOn = 1'b1;

    // R1: reset state at every address
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), v);
      check("R1", "reset readback", v, 0);
    end
    check("R1", "reset irq", int'(irq), 0);

    // R2 / R6: split mode, both halves, random duty
    wr(2'd0, 'h0F);
    edgesLo = 0; edgesHi = 0;
    drvLo = 1'b1; drvHi = 1'b1;
    idle(3000);
    stopDrive();
    wr(2'd0, 'h0C);
    peek(2'd2, lo); peek(2'd3, hi);
    check("R2", "low count vs edges", lo, edgesLo % (MaxV + 1));
    check("R2", "high count vs edges", hi, edgesHi % (MaxV + 1));
    peek(2'd1, v);
    check("R6", "both wrap flags", v, 3);

    // R3: enables clear, run set -> frozen
    savLo = lo; savHi = hi;
    drvLo = 1'b1; drvHi = 1'b1;
    idle(200);
    stopDrive();
    peek(2'd2, lo); peek(2'd3, hi);
    check("R3", "low frozen", lo, savLo);
    check("R3", "high frozen", hi, savHi);
    wr(2'd0, 'h08);
    peek(2'd2, lo); peek(2'd3, hi);
    check("R3", "low held at zero", lo, 0);
    check("R3", "high kept", hi, savHi);

    // R8 / R9: write-one-to-clear, one bit at a time
    wr(2'd1, 'h01);
    peek(2'd1, v);
    check("R8", "clear bit0 only", v, 2);
    check("R9", "irq with flag set", int'(irq), 1);
    wr(2'd1, 'h00);
    peek(2'd1, v);
    check("R8", "write zero keeps flag", v, 2);
    wr(2'd1, 'h02);
    idle(1);
    check("R9", "irq after flags clear", int'(irq), 0);

    // R10: mode write ignored while a half is enabled
    wr(2'd0, 'h0D);
    wr(2'd0, 'h1D);
    peek(2'd0, v);
    check("R10", "mode locked while enabled", v, 'h1D & 'h0F);
    wr(2'd0, 'h00);
    wr(2'd0, 'h10);
    peek(2'd0, v);
    check("R10", "mode taken when stopped", v, 'h10);

    // R4 / R5 / R7: cascade, high input and high enable toggles ignored
    wr(2'd0, 'h1A);
    wr(2'd0, 'h1F);
    edgesLo = 0;
    drvLo = 1'b1; drvHi = 1'b1;
    for (int k = 0; k < 6; k++) begin
      idle(400);
      wr(2'd0, 'h1D);
      idle(300);
      wr(2'd0, 'h1F);
    end
    wait (edgesLo >= 3000);
    stopDrive();
    wr(2'd0, 'h1C);
    peek(2'd2, lo); peek(2'd3, hi);
    check("R4", "cascaded value", hi * (MaxV + 1) + lo, edgesLo);
    peek(2'd1, v);
    check("R7", "no flag on low wraps", v, 0);
    wr(2'd0, 'h1D);
    drvLo = 1'b1;
    wait (edgesLo >= 4200);
    stopDrive();
    wr(2'd0, 'h1C);
    peek(2'd2, lo); peek(2'd3, hi);
    check("R4", "cascaded value after wrap", hi * (MaxV + 1) + lo,
          edgesLo - (MaxV + 1) * (MaxV + 1));
    peek(2'd1, v);
    check("R7", "full wrap sets bit1 only", v, 2);
    wr(2'd1, 'h03);

    // R5: low enable clear, high enable set, high input active
    wr(2'd0, 'h1E);
    savHi = hi;
    drvLo = 1'b1; drvHi = 1'b1;
    idle(300);
    stopDrive();
    peek(2'd3, hi);
    check("R5", "high ignores own input in cascade", hi, savHi);

    // R11: minimum high and low times
    wr(2'd0, 'h00);
    wr(2'd0, 'h0C);
    wr(2'd0, 'h0F);
    peek(2'd0, v);
    check("R10", "back to split mode", v, 'h0F);
    minW = 2; maxW = 2;
    edgesLo = 0; edgesHi = 0;
    drvLo = 1'b1; drvHi = 1'b1;
    idle(500);
    stopDrive();
    peek(2'd2, lo); peek(2'd3, hi);
    check("R11", "low count at max rate", lo, edgesLo % (MaxV + 1));
    check("R11", "high count at max rate", hi, edgesHi % (MaxV + 1));

    idle(4);
    summary();
  end
endmodule